// File: doc/BRIEF.md
# Timer-Clocked Synchronous Serial Port

This block is a byte-wide synchronous serial port for a small CPU-facing peripheral. It has a serial data pin and a serial clock pin. It also has its own down-counting interval timer, which sets the clock rate when the port transmits. In receive mode, an external device clocks bits in. Each rising edge on the clock pin shifts in the current level of the data pin, and eight edges complete a byte. In transmit mode, the port drives the clock pin itself. It toggles the pin once per timer underflow and shifts a CPU-written byte out, most significant bit first.

Completion in either direction raises a serial flag in an interrupt status register. The timer raises a flag of its own on every underflow. Reading the status register clears both flags. An enable register, written with set/clear semantics, decides which flags reach the interrupt line. The CPU side is a plain single-cycle register bus with a combinational read path.

Register map (byte-wide, 3-bit address):
- 0: timer reload value, low byte (write); live counter, low byte (read).
- 1: timer reload value, high byte (write); live counter, high byte (read).
- 2: serial data register.
- 3: interrupt status (read); enable set/clear (write).
- 4: control register.

Top module: `ssp_port`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00 and the live counter reads 0xFFFF. The clock and data outputs sit high, both output enables are low and the interrupt line is low.
- R2: Address 0 writes the low byte of the reload value and address 1 writes the high byte. A write to the control register (address 4) copies the reload value into the counter and sets the run state from control bit 0. While running, the counter decrements once per cycle. When it holds 1 or 0, it reloads instead and signals an underflow. The underflow sets status bit 0. A reload value of N ≥ 1 therefore gives one underflow every N cycles, and a value of 1 gives one every cycle.
- R3: In receive mode (control bit 6 = 0), the clock and data pins each pass through a two-flop synchroniser. Each rising clock edge seen after the synchroniser shifts the data level into the receive register, most significant bit first. On the eighth edge, the assembled byte is written to the serial data register (address 2) and status bit 3 is set.
- R4: In transmit mode (control bit 6 = 1), a write to address 2 while no byte is in flight starts a transfer, with the clock output high. Each timer underflow then toggles the clock output. A high-to-low toggle also puts the next bit on the data output, most significant bit first. On the eighth low-to-high toggle, the transfer ends and status bit 3 is set.
- R5: In transmit mode, the data output changes only together with a falling clock output. It is stable across every rising clock output and throughout each high phase.
- R6: A write to address 2 while a transmit byte is in flight does not alter the bits being sent. The written value is still stored and reads back from address 2.
- R7: Reading address 3 returns the interrupt line in bit 7, the serial flag in bit 3 and the timer flag in bit 0; all other bits read 0. The read clears both flags. A flag event in the same cycle as the read leaves that flag set.
- R8: Writing address 3 with bit 7 = 1 enables every flag whose bit is 1 in the written value. Writing it with bit 7 = 0 disables those flags. Bits written as 0 leave their enables unchanged. Disabling an enable does not clear the flag itself.
- R9: The interrupt output is high exactly while at least one flag is set and also enabled.
- R10: Control bit 6 drives both output enables. Leaving transmit mode abandons a byte in flight. Entering transmit mode discards any partly received byte, so the next receive starts from bit 0.
- R11: In transmit mode with the timer stopped, a started byte does not advance and the clock output stays high. Once the timer runs, the byte completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| cnt_in | input | 1 | Serial clock pin, input level |
| sp_in | input | 1 | Serial data pin, input level |
| cnt_out | output | 1 | Serial clock pin, driven level |
| cnt_oe | output | 1 | Serial clock pin output enable |
| sp_out | output | 1 | Serial data pin, driven level |
| sp_oe | output | 1 | Serial data pin output enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties assume three things about the inputs:
- The bus makes at most one access per cycle.
- The external serial clock holds each level for several block clocks, so the synchroniser never misses an edge.
- The data pin is settled before the clock pin rises.

The stimulus holds each receive-side pin level for three cycles and changes the data only while the clock pin is low. It issues every register access as a single-cycle strobe followed by an idle cycle. Mode changes, stalled transfers and overlapping writes are applied only through the register bus, so the timing relations the properties rely on stay valid.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   localparam int BUS_W = 8;
   localparam int FRAME_BITS = 8;

   localparam logic [2:0] ADR_TLO  = 3'd0;
   localparam logic [2:0] ADR_THI  = 3'd1;
   localparam logic [2:0] ADR_SDR  = 3'd2;
   localparam logic [2:0] ADR_ICR  = 3'd3;
   localparam logic [2:0] ADR_CTRL = 3'd4;

   localparam int FLG_TMR = 0;
   localparam int FLG_SER = 3;
   localparam int CTL_RUN = 0;
   localparam int CTL_OUT = 6;
   localparam int MSK_SET = 7;
endpackage

// File: rtl/ssp_timer.sv
module ssp_timer #(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lo_wr,
   input  logic               hi_wr,
   input  logic               load,
   input  logic               run_d,
   input  logic [7:0]         wdata,
   output logic [TIMER_W-1:0] count,
   output logic               run,
   output logic               uf
);
   localparam int HI_W = TIMER_W - 8;

   logic [TIMER_W-1:0] reload_q;

   assign uf = run && (count <= TIMER_W'(1)) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '1;
      end else begin
         if (lo_wr) reload_q[7:0] <= wdata;
         if (hi_wr) reload_q[TIMER_W-1:8] <= wdata[HI_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '1;
         run   <= 1'b0;
      end else if (load) begin
         count <= reload_q;
         run   <= run_d;
      end else if (uf) begin
         count <= reload_q;
      end else if (run) begin
         count <= count - TIMER_W'(1);
      end
   end
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_BITS  = 8,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  out_mode,
   input  logic                  uf,
   input  logic                  start_wr,
   input  logic [FRAME_BITS-1:0] wdata,
   input  logic                  cnt_in,
   input  logic                  sp_in,
   output logic                  cnt_out,
   output logic                  sp_out,
   output logic                  tx_busy,
   output logic                  tx_done,
   output logic                  rx_done,
   output logic [FRAME_BITS-1:0] rx_byte
);
   localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("ssp_shift: SYNC_STAGES must be 2..4");
   end
   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("ssp_shift: FRAME_BITS must be at least 2");
   end

   logic [SYNC_STAGES-1:0] c_pipe, s_pipe;
   logic                   c_last;
   logic                   rise, s_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_pipe <= '1;
         s_pipe <= '0;
         c_last <= 1'b1;
      end else begin
         c_pipe <= {c_pipe[SYNC_STAGES-2:0], cnt_in};
         s_pipe <= {s_pipe[SYNC_STAGES-2:0], sp_in};
         c_last <= c_pipe[SYNC_STAGES-1];
      end
   end

   assign rise  = c_pipe[SYNC_STAGES-1] & ~c_last;
   assign s_bit = s_pipe[SYNC_STAGES-1];

   logic [FRAME_BITS-1:0] tx_sh, tx_next, rx_sh, rx_next;
   logic                  tx_bit;

   if (MSB_FIRST) begin : g_msb
      assign tx_bit  = tx_sh[FRAME_BITS-1];
      assign tx_next = {tx_sh[FRAME_BITS-2:0], 1'b0};
      assign rx_next = {rx_sh[FRAME_BITS-2:0], s_bit};
   end else begin : g_lsb
      assign tx_bit  = tx_sh[0];
      assign tx_next = {1'b0, tx_sh[FRAME_BITS-1:1]};
      assign rx_next = {s_bit, rx_sh[FRAME_BITS-1:1]};
   end

   logic [CNT_W-1:0] tx_n, rx_n;
   logic             cnt_q, sp_q;

   assign tx_done = out_mode & tx_busy & uf & ~cnt_q & (tx_n == LAST);
   assign rx_done = ~out_mode & rise & (rx_n == LAST);
   assign rx_byte = rx_next;
   assign cnt_out = cnt_q;
   assign sp_out  = sp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_busy <= 1'b0;
         tx_sh   <= '0;
         tx_n    <= '0;
         cnt_q   <= 1'b1;
         sp_q    <= 1'b1;
      end else if (!out_mode) begin
         tx_busy <= 1'b0;
         tx_n    <= '0;
         cnt_q   <= 1'b1;
      end else if (start_wr && !tx_busy) begin
         tx_busy <= 1'b1;
         tx_sh   <= wdata;
         tx_n    <= '0;
         cnt_q   <= 1'b1;
      end else if (tx_busy && uf) begin
         if (cnt_q) begin
            cnt_q <= 1'b0;
            sp_q  <= tx_bit;
            tx_sh <= tx_next;
         end else begin
            cnt_q <= 1'b1;
            if (tx_n == LAST) begin
               tx_busy <= 1'b0;
               tx_n    <= '0;
            end else begin
               tx_n <= tx_n + CNT_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_sh <= '0;
         rx_n  <= '0;
      end else if (out_mode) begin
         rx_n <= '0;
      end else if (rise) begin
         rx_sh <= rx_next;
         rx_n  <= (rx_n == LAST) ? '0 : rx_n + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ssp_irq.sv
module ssp_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_tmr,
   input  logic       set_ser,
   input  logic       rd_clr,
   input  logic       mask_wr,
   input  logic [7:0] wdata,
   output logic [6:0] flags,
   output logic       irq
);
   import ssp_pkg::*;

   localparam logic [6:0] IMPL = 7'((1 << FLG_TMR) | (1 << FLG_SER));

   logic [6:0] set_vec, act;
   logic       unused_wd;

   assign set_vec   = 7'((32'(set_tmr) << FLG_TMR) | (32'(set_ser) << FLG_SER));
   assign unused_wd = ^(wdata & ~{1'b1, IMPL});

   for (genvar i = 0; i < 7; i++) begin : g_bit
      if (IMPL[i]) begin : g_on
         logic f_q, m_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               f_q <= 1'b0;
               m_q <= 1'b0;
            end else begin
               if (set_vec[i])  f_q <= 1'b1;
               else if (rd_clr) f_q <= 1'b0;
               if (mask_wr && wdata[i]) m_q <= wdata[MSK_SET];
            end
         end
         assign flags[i] = f_q;
         assign act[i]   = f_q & m_q;
      end else begin : g_off
         assign flags[i] = 1'b0;
         assign act[i]   = 1'b0;
      end
   end

   assign irq = |act;
endmodule

// File: rtl/ssp_port.sv
module ssp_port #(
   parameter int TIMER_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_cs,
   input  logic       bus_we,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       cnt_in,
   input  logic       sp_in,
   output logic       cnt_out,
   output logic       cnt_oe,
   output logic       sp_out,
   output logic       sp_oe,
   output logic       irq
);
   import ssp_pkg::*;

   if (TIMER_W < 9 || TIMER_W > 16) begin : g_bad_timer
      $error("ssp_port: TIMER_W must be 9..16");
   end

   logic wr, rd;
   logic ctrl_wr, sdr_wr, icr_rd, mask_wr;
   logic out_mode, run, uf;
   logic tx_busy, tx_done, rx_done, flag_ser;
   logic [TIMER_W-1:0]    count;
   logic [FRAME_BITS-1:0] rx_byte, sdr_q;
   logic [6:0]            flags;

   assign wr      = bus_cs & bus_we;
   assign rd      = bus_cs & ~bus_we;
   assign ctrl_wr = wr & (bus_addr == ADR_CTRL);
   assign sdr_wr  = wr & (bus_addr == ADR_SDR);
   assign mask_wr = wr & (bus_addr == ADR_ICR);
   assign icr_rd  = rd & (bus_addr == ADR_ICR);

   always_ff @(posedge clk) begin
      if (!rst_n)       out_mode <= 1'b0;
      else if (ctrl_wr) out_mode <= bus_wdata[CTL_OUT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       sdr_q <= '0;
      else if (rx_done) sdr_q <= rx_byte;
      else if (sdr_wr)  sdr_q <= bus_wdata[FRAME_BITS-1:0];
   end

   ssp_timer #(.TIMER_W(TIMER_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .lo_wr (wr & (bus_addr == ADR_TLO)),
      .hi_wr (wr & (bus_addr == ADR_THI)),
      .load  (ctrl_wr),
      .run_d (bus_wdata[CTL_RUN]),
      .wdata (bus_wdata),
      .count (count),
      .run   (run),
      .uf    (uf)
   );

   ssp_shift #(
      .SYNC_STAGES (SYNC_STAGES),
      .FRAME_BITS  (FRAME_BITS),
      .MSB_FIRST   (1'b1)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_mode (out_mode),
      .uf       (uf),
      .start_wr (sdr_wr),
      .wdata    (bus_wdata[FRAME_BITS-1:0]),
      .cnt_in   (cnt_in),
      .sp_in    (sp_in),
      .cnt_out  (cnt_out),
      .sp_out   (sp_out),
      .tx_busy  (tx_busy),
      .tx_done  (tx_done),
      .rx_done  (rx_done),
      .rx_byte  (rx_byte)
   );

   ssp_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_tmr (uf),
      .set_ser (tx_done | rx_done),
      .rd_clr  (icr_rd),
      .mask_wr (mask_wr),
      .wdata   (bus_wdata),
      .flags   (flags),
      .irq     (irq)
   );

   assign flag_ser = flags[FLG_SER];
   assign cnt_oe   = out_mode;
   assign sp_oe    = out_mode;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_TLO:  bus_rdata = count[7:0];
         ADR_THI:  bus_rdata = 8'(count >> 8);
         ADR_SDR:  bus_rdata = sdr_q;
         ADR_ICR:  bus_rdata = {irq, flags};
         ADR_CTRL: bus_rdata = 8'((32'(out_mode) << CTL_OUT) | (32'(run) << CTL_RUN));
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
   input logic clk,
   input logic rst_n,
   input logic cnt_out,
   input logic cnt_oe,
   input logic sp_out,
   input logic irq,
   input logic uf,
   input logic tx_busy,
   input logic tx_done,
   input logic rx_done,
   input logic icr_rd,
   input logic ctrl_wr,
   input logic flag_ser
);
   AST_SP_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_out) |-> $stable(sp_out)); // R5

   AST_SP_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_out && $past(cnt_out)) |-> $stable(sp_out)); // R5

   AST_CNT_TOGGLE_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_oe && tx_busy && uf) |=> (cnt_out != $past(cnt_out))); // R4

   AST_CNT_QUIET_NO_UF: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_oe && !uf && !ctrl_wr) |=> $stable(cnt_out)); // R11

   AST_FLAG_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done || rx_done) |=> flag_ser); // R3

   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (icr_rd && !uf && !tx_done && !rx_done) |=> !irq); // R7

   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_done, rx_done})); // R10
endmodule

bind ssp_port ssp_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_out  (cnt_out),
   .cnt_oe   (cnt_oe),
   .sp_out   (sp_out),
   .irq      (irq),
   .uf       (uf),
   .tx_busy  (tx_busy),
   .tx_done  (tx_done),
   .rx_done  (rx_done),
   .icr_rd   (icr_rd),
   .ctrl_wr  (ctrl_wr),
   .flag_ser (flag_ser)
);

// File: tb/tb_ssp_port.sv
`timescale 1ns/1ps
module tb_ssp_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0, we = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       cnt_in = 1'b1, sp_in = 1'b0;
   logic       cnt_out, cnt_oe, sp_out, sp_oe, irq;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ssp_port dut (
      .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_we(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .cnt_in(cnt_in), .sp_in(sp_in),
      .cnt_out(cnt_out), .cnt_oe(cnt_oe), .sp_out(sp_out), .sp_oe(sp_oe), .irq(irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_latch, m_count;
   logic        m_run, m_out, m_txb, m_cntq, m_spq;
   logic [7:0]  m_txsh, m_rxsh, m_sdr;
   int          m_txn, m_rxn;
   logic        m_c0, m_c1, m_clast, m_s0, m_s1;
   logic        m_ft, m_fs, m_kt, m_ks;
   logic        e_wr, e_rd, e_ctl, e_sdr, e_icr, e_uf, e_rise, e_txd, e_rxd;
   logic [7:0]  e_rxb;

   function automatic logic m_irq();
      return (m_ft && m_kt) || (m_fs && m_ks);
   endfunction

   function automatic logic [7:0] m_rdata(input logic [2:0] a);
      case (a)
         3'd0: return m_count[7:0];
         3'd1: return m_count[15:8];
         3'd2: return m_sdr;
         3'd3: return {m_irq(), 3'b000, m_fs, 2'b00, m_ft};
         3'd4: return {1'b0, m_out, 5'b00000, m_run};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_latch = 16'hFFFF; m_count = 16'hFFFF; m_run = 0; m_out = 0;
         m_txb = 0; m_cntq = 1; m_spq = 1; m_txsh = 0; m_rxsh = 0; m_sdr = 0;
         m_txn = 0; m_rxn = 0; m_c0 = 1; m_c1 = 1; m_clast = 1; m_s0 = 0; m_s1 = 0;
         m_ft = 0; m_fs = 0; m_kt = 0; m_ks = 0;
      end else begin
         e_wr  = cs && we;
         e_rd  = cs && !we;
         e_ctl = e_wr && addr == 3'd4;
         e_sdr = e_wr && addr == 3'd2;
         e_icr = e_rd && addr == 3'd3;
         e_uf  = m_run && (m_count <= 16'd1) && !e_ctl;
         e_rise = m_c1 && !m_clast;
         e_rxb = {m_rxsh[6:0], m_s1};
         e_txd = m_out && m_txb && e_uf && !m_cntq && m_txn == 7;
         e_rxd = !m_out && e_rise && m_rxn == 7;
         // timer
         if (e_ctl) begin m_count = m_latch; m_run = wdata[0]; end
         else if (e_uf) m_count = m_latch;
         else if (m_run) m_count = m_count - 16'd1;
         if (e_wr && addr == 3'd0) m_latch[7:0] = wdata;
         if (e_wr && addr == 3'd1) m_latch[15:8] = wdata;
         // transmit
         if (!m_out) begin m_txb = 0; m_txn = 0; m_cntq = 1; end
         else if (e_sdr && !m_txb) begin m_txb = 1; m_txsh = wdata; m_txn = 0; m_cntq = 1; end
         else if (m_txb && e_uf) begin
            if (m_cntq) begin m_cntq = 0; m_spq = m_txsh[7]; m_txsh = m_txsh << 1; end
            else begin
               m_cntq = 1;
               if (m_txn == 7) begin m_txb = 0; m_txn = 0; end else m_txn++;
            end
         end
         // receive
         if (m_out) m_rxn = 0;
         else if (e_rise) begin m_rxsh = e_rxb; m_rxn = (m_rxn == 7) ? 0 : m_rxn + 1; end
         m_clast = m_c1; m_c1 = m_c0; m_c0 = cnt_in; m_s1 = m_s0; m_s0 = sp_in;
         // data register
         if (e_rxd) m_sdr = e_rxb; else if (e_sdr) m_sdr = wdata;
         // flags and enables
         if (e_uf) m_ft = 1; else if (e_icr) m_ft = 0;
         if (e_txd || e_rxd) m_fs = 1; else if (e_icr) m_fs = 0;
         if (e_wr && addr == 3'd3) begin
            if (wdata[0]) m_kt = wdata[7];
            if (wdata[3]) m_ks = wdata[7];
         end
         // mode last: the shifters above used the old mode
         if (e_ctl) m_out = wdata[6];
      end
   end

   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R4", "cnt_out", 16'(cnt_out), 16'(m_cntq));
         chk("R4", "sp_out", 16'(sp_out), 16'(m_spq));
         chk("R10", "cnt_oe", 16'(cnt_oe), 16'(m_out));
         chk("R10", "sp_oe", 16'(sp_oe), 16'(m_out));
         chk("R9", "irq", 16'(irq), 16'(m_irq()));
         case (addr)
            3'd0, 3'd1: chk("R2", "rdata", 16'(rdata), 16'(m_rdata(addr)));
            3'd2:       chk("R3", "rdata", 16'(rdata), 16'(m_rdata(addr)));
            3'd3:       chk("R7", "rdata", 16'(rdata), 16'(m_rdata(addr)));
            default:    chk("R10", "rdata", 16'(rdata), 16'(m_rdata(addr)));
         endcase
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
      @(negedge clk); cs = 0; we = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); cs = 1; we = 0; addr = a;
      #1 d = rdata;
      @(negedge clk); cs = 0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); cnt_in = 0; sp_in = b;
      repeat (3) @(negedge clk);
      cnt_in = 1;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      repeat (3) @(negedge clk);
   endtask

   task automatic capture(output logic [7:0] b, output int n, output int viol);
      logic pc, ps;
      b = 0; n = 0; viol = 0; pc = cnt_out; ps = sp_out;
      for (int i = 0; i < 600 && n < 8; i++) begin
         @(negedge clk);
         if (cnt_out && pc && sp_out !== ps) viol++;
         if (cnt_out && !pc) begin b = {b[6:0], sp_out}; n++; end
         pc = cnt_out; ps = sp_out;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL R4 watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] got;
      int n, viol, falls;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "cnt_out", 16'(cnt_out), 16'd1);
      chk("R1", "sp_out", 16'(sp_out), 16'd1);
      chk("R1", "oe", 16'({cnt_oe, sp_oe}), 16'd0);
      chk("R1", "irq", 16'(irq), 16'd0);
      rd(3'd3, d); chk("R1", "status", 16'(d), 16'h00);
      rd(3'd4, d); chk("R1", "control", 16'(d), 16'h00);
      rd(3'd0, d); chk("R1", "count lo", 16'(d), 16'hFF);
      rd(3'd1, d); chk("R1", "count hi", 16'(d), 16'hFF);

      // R3 receive with timer stopped
      send_byte(8'h56);
      rd(3'd2, d); chk("R3", "rx byte", 16'(d), 16'h56);
      rd(3'd3, d); chk("R3", "status after rx", 16'(d), 16'h08);
      rd(3'd3, d); chk("R7", "status cleared", 16'(d), 16'h00);

      // R8 / R9 enables
      wr(3'd3, 8'h88);
      chk("R9", "irq no flag", 16'(irq), 16'd0);
      send_byte(8'hC3);
      chk("R9", "irq flag+enable", 16'(irq), 16'd1);
      rd(3'd3, d); chk("R7", "status irq bit", 16'(d), 16'h88);
      chk("R7", "irq after read", 16'(irq), 16'd0);
      send_byte(8'h11);
      chk("R9", "irq second", 16'(irq), 16'd1);
      wr(3'd3, 8'h08);
      chk("R8", "irq disabled", 16'(irq), 16'd0);
      rd(3'd3, d); chk("R8", "flag kept", 16'(d), 16'h08);

      // R10 abort of partial receive
      send_bit(1); send_bit(1); send_bit(1); send_bit(1);
      wr(3'd4, 8'h40);
      chk("R10", "oe in tx mode", 16'({cnt_oe, sp_oe}), 16'h3);
      wr(3'd4, 8'h00);
      send_byte(8'h3C);
      rd(3'd2, d); chk("R10", "rx after mode flip", 16'(d), 16'h3C);

      // R11 stalled transmit
      wr(3'd0, 8'h01); wr(3'd1, 8'h00);
      wr(3'd4, 8'h40);
      wr(3'd2, 8'h99);
      falls = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!cnt_out) falls++;
      end
      chk("R11", "cnt low while stopped", 16'(falls), 16'd0);
      fork
         capture(got, n, viol);
         wr(3'd4, 8'hC1);
      join
      chk("R11", "resumed byte", 16'(got), 16'h99);
      chk("R11", "rising edges", 16'(n), 16'd8);

      // R4 / R5 / R6 transmit with overlapping write
      wr(3'd0, 8'h03);
      wr(3'd2, 8'hA5);
      fork
         capture(got, n, viol);
         wr(3'd2, 8'h3C);
      join
      chk("R4", "tx byte", 16'(got), 16'hA5);
      chk("R5", "sp changes while high", 16'(viol), 16'd0);
      chk("R6", "in-flight byte intact", 16'(got), 16'hA5);
      rd(3'd2, d); chk("R6", "data reg readback", 16'(d), 16'h3C);
      rd(3'd3, d); chk("R4", "status after tx", 16'(d), 16'h09);

      // R7 flag set in same cycle as read survives
      wr(3'd0, 8'h01);
      wr(3'd4, 8'h01);
      rd(3'd3, d);
      rd(3'd3, d); chk("R7", "set wins over clear", 16'(d), 16'h01);

      // R2 timer period
      wr(3'd0, 8'h05); wr(3'd1, 8'h00);
      wr(3'd4, 8'h01);
      rd(3'd0, d); chk("R2", "count lo", 16'(d), 16'h04);
      rd(3'd1, d); chk("R2", "count hi", 16'(d), 16'h00);
      rd(3'd4, d); chk("R2", "control", 16'(d), 16'h01);
      repeat (20) @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule